// File: doc/BRIEF.md
# Top-Relative Eight-Level Register Stack

This block holds the operand registers of a floating-point unit as an eight-deep stack. Every register is named by its distance from the current top of stack: `st0` is the top, and `st(i)` lies `i` places below it. A 3-bit top pointer moves down on a push and up on a pop. Each physical entry carries a valid tag, so the block can flag a push into an occupied slot (overflow) and any use of an empty slot (underflow).

The arithmetic unit drives one operation per cycle on `op_i`, with an offset `idx_i` and a flag `use_idx_i` that selects an explicit operand. Both source operands appear combinationally on `opa_o` (always `st0`) and `opb_o` (by default `st1`, or `st(idx_i)` when an explicit operand is named). A result is written back through `wdata_i`. A single exchange operation swaps `st0` with `st(i)` in one cycle. Errors are reported as one-cycle pulses in the cycle after the operation, and a failed operation changes neither data, tags nor pointer.

Top module: `stack_regfile`

## Requirements
- R1: During and after reset the top pointer is 0, all eight entries are empty (`opa_vld_o` and `opb_vld_o` low), and both error pulses are low.
- R2: PUSH (`op_i`=1) into an empty slot decrements the top pointer by one and stores `wdata_i` so that it reads back as `st0`.
- R3: A PUSH while the slot above the top is valid raises `ovf_o` in the following cycle and leaves pointer, tags and data unchanged.
- R4: POP (`op_i`=2) of a valid `st0` marks that entry empty and increments the pointer, so the old `st1` becomes `st0`.
- R5: POP of an empty `st0` raises `unf_o` in the following cycle and changes nothing.
- R6: `opa_o` always shows `st0`. `opb_o` shows `st1` when `use_idx_i`=0 and `st(idx_i)` when `use_idx_i`=1. Each valid output reflects the tag of its entry. The physical entry of `st(i)` is (top + i) mod 8.
- R7: READ (`op_i`=3) raises `unf_o` in the following cycle if either selected source is empty.
- R8: WRITE (`op_i`=4) stores `wdata_i` into `st0` when `use_idx_i`=0 or into `st(idx_i)` when `use_idx_i`=1. An empty target raises `unf_o` and is left unwritten.
- R9: WRITE-POP (`op_i`=5) writes `wdata_i` to `st1` (or to `st(idx_i)` when `use_idx_i`=1) and then pops, so the result reads as `st(i-1)`. If `st0` or the target is empty, `unf_o` is raised and nothing changes.
- R10: EXCHANGE (`op_i`=6) swaps `st0` with `st(idx_i)` in one cycle. It raises `unf_o` and changes nothing if either entry is empty.
- R11: `ovf_o` and `unf_o` are single-cycle pulses tied to the operation of the previous cycle. They are never high together, and NOP (`op_i`=0 or 7) leaves both low.
- R12: The top pointer wraps modulo 8, so the first push after reset moves it from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code (0 NOP, 1 PUSH, 2 POP, 3 READ, 4 WRITE, 5 WRITE-POP, 6 EXCHANGE) |
| idx_i | input | 3 | Stack offset i of the explicit operand |
| use_idx_i | input | 1 | Use `st(idx_i)` in place of the default operand |
| wdata_i | input | W | Data for push or write |
| opa_o | output | W | Value of `st0` |
| opb_o | output | W | Value of the second source operand |
| opa_vld_o | output | 1 | `st0` tag is valid |
| opb_vld_o | output | 1 | Second source tag is valid |
| top_o | output | 3 | Current top-of-stack pointer |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
The bench aims at the pointer wrap from 0 to 7 on the first push. A design that treats the pointer as absolute would leave the new value in the wrong slot, and it would show up as `st7` instead of `st0`. A ninth push must be refused: a design that overwrote it would lose the oldest value and still report a full stack. WRITE-POP with an explicit offset is checked to land at `st(i-1)`, which catches designs that pop before writing. An exchange with offset 0 and exchanges near the wrap boundary are checked for a clean swap with no stale duplicate. Random mixes of operations are run against a bench model that holds its own tags, and they expose any failed operation that still moves the pointer or clears a tag.

// File: rtl/stk_pkg.sv
// Package: shared operation codes and sizing for the register stack.
// Assumes the stack depth is a power of two so that offsets wrap naturally.
package stk_pkg;
    localparam int STK_DEPTH = 8;
    localparam int STK_AW    = $clog2(STK_DEPTH);

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_READ  = 3'd3,
        OP_WRITE = 3'd4,
        OP_WPOP  = 3'd5,
        OP_XCHG  = 3'd6,
        OP_RSVD  = 3'd7
    } stk_op_e;
endpackage

// File: rtl/stk_ptr.sv
// Module: top-of-stack pointer. Moves down by one on dec, up by one on inc,
// and wraps modulo 2**AW. Assumes inc and dec are never asserted together.
module stk_ptr #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] top
);
    // Pointer register: reset to zero, then step by one per push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)   top <= '0;
        else if (dec) top <= top - AW'(1);
        else if (inc) top <= top + AW'(1);
    end

    // R12
    ptr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (top == AW'($past(top) - AW'(1))));
    // R4
    ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (top == AW'($past(top) + AW'(1))));
    // R11
    ptr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));
endmodule

// File: rtl/stk_tags.sv
// Module: per-entry valid tags. One set port (push) and one clear port (pop).
// Assumes control only sets empty entries and only clears valid ones.
module stk_tags #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    output logic [N-1:0]  tag
);
    for (genvar e = 0; e < N; e++) begin : g_tag
        // Tag bit: cleared on reset, raised by push, dropped by pop.
        always_ff @(posedge clk) begin
            if (!rst_n)                                     tag[e] <= 1'b0;
            else if (set_en && set_idx == AW'(e))           tag[e] <= 1'b1;
            else if (clr_en && clr_idx == AW'(e))           tag[e] <= 1'b0;
        end
    end

    // R3
    no_set_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !tag[set_idx]);
    // R5
    no_clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> tag[clr_idx]);
    // R11
    tag_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));
endmodule

// File: rtl/stk_data.sv
// Module: data storage with two write ports and three combinational read
// ports. Port 1 wins when both ports write the same entry.
module stk_data #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [W-1:0]  wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [W-1:0]  wd1,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] mem [N];

    for (genvar e = 0; e < N; e++) begin : g_ent
        // Entry register: cleared on reset, loaded from the winning port.
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem[e] <= '0;
            else if (we1 && wa1 == AW'(e))       mem[e] <= wd1;
            else if (we0 && wa0 == AW'(e))       mem[e] <= wd0;
        end
    end

    // Read muxes: one per source port.
    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];
    assign rd2 = mem[ra2];

    // R8
    wr_port1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we1 |=> (mem[$past(wa1)] == $past(wd1)));
    // R8
    wr_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && !(we1 && wa1 == wa0)) |=> (mem[$past(wa0)] == $past(wd0)));
endmodule

// File: rtl/stack_regfile.sv
// Module: eight-level register stack addressed relative to the top pointer.
// Decodes one operation per cycle, guards it with the valid tags, and
// reports overflow/underflow one cycle later. A refused operation changes
// nothing. Assumes DEPTH is a power of two.
module stack_regfile
    import stk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = STK_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [AW-1:0] idx_i,
    input  logic          use_idx_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  opa_o,
    output logic [W-1:0]  opb_o,
    output logic          opa_vld_o,
    output logic          opb_vld_o,
    output logic [AW-1:0] top_o,
    output logic          ovf_o,
    output logic          unf_o
);
    stk_op_e       op;
    logic [AW-1:0] top, bsel, wsel, pa, pb, pw, pn;
    logic [DEPTH-1:0] tag;
    logic [W-1:0]  rd0, rd1, rd2;
    logic          push_ok, pop_ok, write_ok, wpop_ok, xchg_ok;
    logic          ovf_d, unf_d;
    logic          we0, we1;
    logic [AW-1:0] wa0, wa1;
    logic [W-1:0]  wd0, wd1;

    assign op = stk_op_e'(op_i);

    // Operand offsets: default source is st1; write target depends on the op.
    always_comb begin
        bsel = use_idx_i ? idx_i : AW'(1);
        if (op == OP_XCHG)                     wsel = idx_i;
        else if (op == OP_WRITE && !use_idx_i) wsel = '0;
        else                                   wsel = bsel;
    end

    // Physical indices: relative offsets added to the top pointer modulo DEPTH.
    assign pa = top;
    assign pb = top + bsel;
    assign pw = top + wsel;
    assign pn = top - AW'(1);

    // Guarded operation enables and error detection.
    always_comb begin
        push_ok  = 1'b0;
        pop_ok   = 1'b0;
        write_ok = 1'b0;
        wpop_ok  = 1'b0;
        xchg_ok  = 1'b0;
        ovf_d    = 1'b0;
        unf_d    = 1'b0;
        unique case (op)
            OP_PUSH:  begin push_ok  = !tag[pn];            ovf_d = tag[pn];               end
            OP_POP:   begin pop_ok   = tag[pa];             unf_d = !tag[pa];              end
            OP_READ:  begin                                 unf_d = !tag[pa] || !tag[pb];  end
            OP_WRITE: begin write_ok = tag[pw];             unf_d = !tag[pw];              end
            OP_WPOP:  begin wpop_ok  = tag[pa] && tag[pw];  unf_d = !(tag[pa] && tag[pw]); end
            OP_XCHG:  begin xchg_ok  = tag[pa] && tag[pw];  unf_d = !(tag[pa] && tag[pw]); end
            default:  begin end
        endcase
    end

    // Write-port steering: push and writes use port 0; exchange uses both.
    always_comb begin
        we0 = 1'b0;  wa0 = pw;  wd0 = wdata_i;
        we1 = 1'b0;  wa1 = pw;  wd1 = rd0;
        if (push_ok) begin
            we0 = 1'b1;
            wa0 = pn;
        end else if (write_ok || wpop_ok) begin
            we0 = 1'b1;
        end else if (xchg_ok) begin
            we0 = 1'b1;
            wa0 = pa;
            wd0 = rd2;
            we1 = 1'b1;
        end
    end

    stk_ptr #(.AW(AW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pop_ok || wpop_ok),
        .dec   (push_ok),
        .top   (top)
    );

    stk_tags #(.N(DEPTH), .AW(AW)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (push_ok),
        .set_idx (pn),
        .clr_en  (pop_ok || wpop_ok),
        .clr_idx (pa),
        .tag     (tag)
    );

    stk_data #(.W(W), .N(DEPTH), .AW(AW)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .we0   (we0),
        .wa0   (wa0),
        .wd0   (wd0),
        .we1   (we1),
        .wa1   (wa1),
        .wd1   (wd1),
        .ra0   (pa),
        .ra1   (pb),
        .ra2   (pw),
        .rd0   (rd0),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    // Error pulse registers: one cycle after the offending operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            ovf_o <= ovf_d;
            unf_o <= unf_d;
        end
    end

    assign opa_o     = rd0;
    assign opb_o     = rd1;
    assign opa_vld_o = tag[pa];
    assign opb_vld_o = tag[pb];
    assign top_o     = top;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (top_o == '0 && !ovf_o && !unf_o && !opa_vld_o));
    // R2
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (opa_vld_o && opa_o == $past(wdata_i)));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && !push_ok) |=> (ovf_o && $stable(top_o)));
    // R5
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && !pop_ok) |=> (unf_o && $stable(top_o)));
    // R10
    xchg_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_ok |=> (opa_o == $past(rd2)));
    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));
endmodule

// File: tb/sim_stack_regfile.sv
module sim_stack_regfile;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = 3'd0;
    logic [2:0]   idx_i = 3'd0;
    logic         use_idx_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] opa_o, opb_o;
    logic         opa_vld_o, opb_vld_o, ovf_o, unf_o;
    logic [2:0]   top_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model state
    logic [W-1:0] m [8];
    logic [7:0]   mt;
    logic [2:0]   mtp;

    always #5 clk = ~clk;

    stack_regfile #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i),
        .use_idx_i(use_idx_i), .wdata_i(wdata_i), .opa_o(opa_o), .opb_o(opb_o),
        .opa_vld_o(opa_vld_o), .opb_vld_o(opb_vld_o), .top_o(top_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd1: return "R2/R3";
            3'd2: return "R4/R5";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    // One operation: check sources, clock it, check flags and new state.
    task automatic step(input logic [2:0] op, input logic [2:0] idx,
                        input logic ui, input logic [W-1:0] d);
        logic [2:0] b, pw, pn;
        logic eo, eu;
        logic [W-1:0] tmp;
        @(negedge clk);
        op_i = op; idx_i = idx; use_idx_i = ui; wdata_i = d;
        #1;
        b  = mtp + (ui ? idx : 3'd1);
        pn = mtp - 3'd1;
        if (op == 3'd6)           pw = mtp + idx;
        else if (op == 3'd4 && !ui) pw = mtp;
        else                      pw = b;
        chk("R6 opa", opa_o, m[mtp]);
        chk("R6 opa_vld", opa_vld_o, mt[mtp]);
        chk("R6 opb", opb_o, m[b]);
        chk("R6 opb_vld", opb_vld_o, mt[b]);
        eo = 1'b0; eu = 1'b0;
        case (op)
            3'd1: if (mt[pn]) eo = 1'b1;
                  else begin m[pn] = d; mt[pn] = 1'b1; mtp = pn; end
            3'd2: if (!mt[mtp]) eu = 1'b1;
                  else begin mt[mtp] = 1'b0; mtp = mtp + 3'd1; end
            3'd3: eu = !mt[mtp] || !mt[b];
            3'd4: if (!mt[pw]) eu = 1'b1; else m[pw] = d;
            3'd5: if (!mt[mtp] || !mt[pw]) eu = 1'b1;
                  else begin m[pw] = d; mt[mtp] = 1'b0; mtp = mtp + 3'd1; end
            3'd6: if (!mt[mtp] || !mt[pw]) eu = 1'b1;
                  else begin tmp = m[mtp]; m[mtp] = m[pw]; m[pw] = tmp; end
            default: ;
        endcase
        @(posedge clk);
        #1;
        chk({op_tag(op), " ovf"}, ovf_o, eo);
        chk({op_tag(op), " unf"}, unf_o, eu);
        chk("R12 top", top_o, mtp);
        if (op == 3'd1 && !eo) chk("R2 st0 after push", opa_o, d);
        if (op == 3'd2 && !eu) chk("R4 st0 after pop", {opa_vld_o, opa_o}, {mt[mtp], m[mtp]});
        if (op == 3'd5 && !eu) chk("R9 result slot", m[pw], d);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] rop;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m[i] = '0;
        mt = '0; mtp = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 top in reset", top_o, 3'd0);
        chk("R1 ovf in reset", ovf_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 empty st0", opa_vld_o, 1'b0);
        chk("R1 unf after reset", unf_o, 1'b0);

        // Empty-stack underflows
        step(3'd2, 3'd0, 1'b0, '0);
        step(3'd3, 3'd0, 1'b0, '0);
        step(3'd6, 3'd2, 1'b0, '0);
        step(3'd0, 3'd0, 1'b0, '0);
        // First push wraps pointer to 7, then fill
        step(3'd1, 3'd0, 1'b0, 16'h1111);
        chk("R12 wrap to 7", top_o, 3'd7);
        for (int k = 1; k < 8; k++) step(3'd1, 3'd0, 1'b0, W'(16'h1000 + k));
        step(3'd1, 3'd0, 1'b0, 16'hdead);
        chk("R3 refused push keeps st0", opa_o, 16'h1007);
        step(3'd0, 3'd0, 1'b0, '0);
        // Operand pairing
        step(3'd3, 3'd0, 1'b0, '0);
        step(3'd3, 3'd5, 1'b1, '0);
        // Writes
        step(3'd4, 3'd0, 1'b0, 16'haaaa);
        step(3'd4, 3'd3, 1'b1, 16'hbbbb);
        // Exchanges, including offset 0 and the wrap boundary
        step(3'd6, 3'd5, 1'b0, '0);
        step(3'd6, 3'd0, 1'b0, '0);
        step(3'd6, 3'd7, 1'b0, '0);
        // Write-pop default and explicit
        step(3'd5, 3'd0, 1'b0, 16'hcccc);
        chk("R9 default result is st0", opa_o, 16'hcccc);
        step(3'd5, 3'd3, 1'b1, 16'hdddd);
        step(3'd3, 3'd2, 1'b1, '0);
        chk("R9 explicit result at st(i-1)", opb_o, 16'hdddd);
        // Drain and over-pop
        for (int k = 0; k < 7; k++) step(3'd2, 3'd0, 1'b0, '0);
        step(3'd4, 3'd0, 1'b0, 16'heeee);
        step(3'd5, 3'd0, 1'b0, 16'heeee);
        // Random mix
        for (int n = 0; n < 600; n++) begin
            rop = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) rop = 3'd1;
            step(rop, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 W'($urandom));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule